// File: doc/BRIEF.md
# I2C Register Slave

This block is a slave on a two-wire I2C bus. It lets an external bus master read and write a bank of byte-wide registers that sit outside the block. All bus activity is sampled into the system clock domain. The block finds start and stop conditions and checks the first byte of each transfer against its own bus address. After an address match it takes part in the transfer: it receives a register pointer and then write data, or it sends register contents back one byte after another.

The block drives the bus data line only through an open-drain enable: `sda_oe` high means "pull SDA low". It never drives the line high. The register bank is reached through a plain port. The block presents a register index, and for a write it adds a data byte and a one-cycle strobe. The bank returns the byte at the presented index on `reg_rdata`, with no clock cycle of delay. Two pins select the low two bits of the bus address. Up to four such slaves can therefore share one bus.

Top module: `i2c_reg_slave`

## Requirements
- R1: The 7-bit bus address is 0b00100 in its five high bits, followed by `cfg_a1` and then `cfg_a0`. When the first byte after a start carries this address, the block pulls SDA low for the whole ninth SCL clock of that byte.
- R2: When the address in the first byte does not match, the block leaves SDA released for that byte and for every later byte, and issues no register write until the next start condition.
- R3: In a write transfer (bit 0 of the first byte is 0), the next byte is the register pointer. Its low log2(NUM_REGS) bits are kept, and the byte is acknowledged.
- R4: In a write transfer, every further byte is acknowledged and written to the register at the pointer with a `reg_we` pulse of exactly one cycle. The pointer then advances by one.
- R5: When bit 0 of the first byte is 1, the block sends the register at the current pointer, most significant bit first, and releases SDA during the ninth clock. While the master acknowledges, each further byte comes from the next register.
- R6: After the master does not acknowledge a read byte, the block keeps SDA released until the next start condition.
- R7: The pointer wraps from register NUM_REGS-1 to register 0, both in write bursts and in read bursts.
- R8: A start or stop condition at any bit position ends the byte in progress. A partly received byte is never written. SDA is released after a start or a stop. A repeated start after a pointer write begins a read at that pointer.
- R9: SCL and SDA pass through a two-stage synchronizer. The SDA enable changes only while the synchronized SCL is low.
- R10: While reset is asserted, `sda_oe` and `reg_we` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain) |
| cfg_a1 | input | 1 | Bus address bit 1 select pin |
| cfg_a0 | input | 1 | Bus address bit 0 select pin |
| reg_addr | output | log2(NUM_REGS) | Register index (pointer) |
| reg_wdata | output | 8 | Write data byte |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Byte at `reg_addr`, no latency |

## Verification
The hardest situations to reach are a start or stop condition that lands in the middle of a data byte, and a burst that crosses the top register. Neither shows up in ordinary transfers.

The bench master builds these cases bit by bit. It clocks out only part of a byte after a valid pointer and then issues a new start, or a stop. It then reads the affected registers back through a fresh transfer, which proves that no partial byte was written. Write and read bursts begin one or two registers below the top, so that the wrap to register 0 appears on the data port and on the bus in a single transfer.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
   localparam int BYTE_W = 8;
   localparam logic [4:0] DEV_PREFIX = 5'b00100;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_RX_ACK,
      PH_TX,
      PH_TX_ACK
   } phase_e;

   typedef enum logic [1:0] {
      BK_DEV,
      BK_PTR,
      BK_DATA
   } bkind_e;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_slv_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_slv_engine.sv
module i2c_slv_engine
   import i2c_slv_pkg::*;
#(
   parameter int RA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_s,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              cfg_a1,
   input  logic              cfg_a0,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sda_oe,
   output logic [RA_W-1:0]   ptr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              wr_en
);
   phase_e            phase;
   bkind_e            kind;
   logic [3:0]        bcnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] txsh;
   logic              rw;
   logic              mack;
   logic [6:0]        my_dev;

   assign my_dev = {DEV_PREFIX, cfg_a1, cfg_a0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         kind    <= BK_DEV;
         bcnt    <= '0;
         shreg   <= '0;
         txsh    <= '0;
         rw      <= 1'b0;
         mack    <= 1'b0;
         ptr     <= '0;
         wr_data <= '0;
         wr_en   <= 1'b0;
         sda_oe  <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (wr_en) begin
            ptr <= ptr + 1'b1;
         end
         if (start_det) begin
            phase  <= PH_RX;
            kind   <= BK_DEV;
            bcnt   <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (phase)
               PH_RX: begin
                  if (scl_rise) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     bcnt  <= bcnt + 1'b1;
                  end else if (scl_fall && bcnt == 4'd8) begin
                     case (kind)
                        BK_DEV: begin
                           if (shreg[7:1] == my_dev) begin
                              rw     <= shreg[0];
                              sda_oe <= 1'b1;
                              phase  <= PH_RX_ACK;
                           end else begin
                              phase <= PH_IDLE;
                           end
                        end
                        BK_PTR: begin
                           ptr    <= shreg[RA_W-1:0];
                           sda_oe <= 1'b1;
                           phase  <= PH_RX_ACK;
                        end
                        default: begin
                           wr_en   <= 1'b1;
                           wr_data <= shreg;
                           sda_oe  <= 1'b1;
                           phase   <= PH_RX_ACK;
                        end
                     endcase
                  end
               end
               PH_RX_ACK: begin
                  if (scl_rise) begin
                     bcnt <= bcnt + 1'b1;
                  end else if (scl_fall && bcnt == 4'd9) begin
                     bcnt <= '0;
                     if (kind == BK_DEV && rw) begin
                        txsh   <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                        ptr    <= ptr + 1'b1;
                        phase  <= PH_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        phase  <= PH_RX;
                        kind   <= (kind == BK_DEV) ? BK_PTR : BK_DATA;
                     end
                  end
               end
               PH_TX: begin
                  if (scl_rise) begin
                     bcnt <= bcnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bcnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        phase  <= PH_TX_ACK;
                     end else begin
                        txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~txsh[BYTE_W-2];
                     end
                  end
               end
               PH_TX_ACK: begin
                  if (scl_rise) begin
                     bcnt <= bcnt + 1'b1;
                     mack <= ~sda_s;
                  end else if (scl_fall && bcnt == 4'd9) begin
                     bcnt <= '0;
                     if (mack) begin
                        txsh   <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                        ptr    <= ptr + 1'b1;
                        phase  <= PH_TX;
                     end else begin
                        phase <= PH_IDLE;
                     end
                  end
               end
               default: begin
                  phase <= PH_IDLE;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
   import i2c_slv_pkg::*;
#(
   parameter int NUM_REGS    = 16,
   parameter int SYNC_STAGES = 2,
   localparam int RA_W       = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              cfg_a1,
   input  logic              cfg_a0,
   output logic [RA_W-1:0]   reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [BYTE_W-1:0] reg_rdata
);
   generate
      if (NUM_REGS < 2 || NUM_REGS > 256 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
         $error("i2c_reg_slave: NUM_REGS must be a power of two from 2 to 256");
      end
   endgenerate

   logic scl_s;
   logic sda_s;
   logic scl_rise;
   logic scl_fall;
   logic start_det;
   logic stop_det;

   i2c_slv_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_slv_engine #(
      .RA_W (RA_W)
   ) i_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_s     (sda_s),
      .start_det (start_det),
      .stop_det  (stop_det),
      .cfg_a1    (cfg_a1),
      .cfg_a0    (cfg_a0),
      .rd_data   (reg_rdata),
      .sda_oe    (sda_oe),
      .ptr       (reg_addr),
      .wr_data   (reg_wdata),
      .wr_en     (reg_we)
   );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
   parameter int NUM_REGS = 16,
   localparam int RA_W    = $clog2(NUM_REGS)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            sda_oe,
   input logic            scl_s,
   input logic            start_det,
   input logic            stop_det,
   input logic            reg_we,
   input logic [RA_W-1:0] reg_addr
);
   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_s)); // R9
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe); // R8
   AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe); // R8
   AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we); // R4
   AST_WE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> reg_addr == RA_W'($past(reg_addr) + 1'b1)); // R7
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!sda_oe && !reg_we)); // R10
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(
   .NUM_REGS (NUM_REGS)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sda_oe    (sda_oe),
   .scl_s     (scl_s),
   .start_det (start_det),
   .stop_det  (stop_det),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr)
);

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
   localparam int CLK_PERIOD = 10;
   localparam int NREG       = 16;
   localparam int AW         = 4;
   localparam int QTR        = 6;
   localparam int WD_LIMIT   = 150000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           scl = 1'b1;
   logic           sda_m = 1'b1;
   logic           sda_line;
   logic           sda_oe;
   logic           cfg_a1 = 1'b1;
   logic           cfg_a0 = 1'b0;
   logic [AW-1:0]  reg_addr;
   logic [7:0]     reg_wdata;
   logic           reg_we;
   logic [7:0]     reg_rdata;
   logic [7:0]     regs [NREG];
   logic [7:0]     exp_mem [NREG];
   logic [AW+7:0]  expq [$];
   logic [AW-1:0]  ptr_model = '0;
   int             total = 0;
   int             bad = 0;
   logic           oe_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line  = sda_m & ~sda_oe;
   assign reg_rdata = regs[reg_addr];

   always @(posedge clk) begin
      if (reg_we) regs[reg_addr] <= reg_wdata;
   end

   i2c_reg_slave #(.NUM_REGS(NREG)) i_i2c_reg_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .cfg_a1    (cfg_a1),
      .cfg_a0    (cfg_a0),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rdata (reg_rdata)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: register writes against the expected queue
   always @(negedge clk) begin
      if (rst_n && reg_we) begin
         if (expq.size() == 0) begin
            check(1'b0, "R2 unexpected write", {reg_addr, reg_wdata}, 0);
         end else begin
            logic [AW+7:0] e;
            e = expq.pop_front();
            check({reg_addr, reg_wdata} == e, "R4 write", {reg_addr, reg_wdata}, e);
         end
      end
      if (rst_n && sda_oe != oe_prev) begin
         check(scl == 1'b0, "R9 sda change while scl high", scl, 0);
      end
      oe_prev = sda_oe;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; tick(QTR);
      scl = 1'b1;   tick(QTR);
      sda_m = 1'b0; tick(QTR);
      scl = 1'b0;   tick(QTR);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; tick(QTR);
      scl = 1'b1;   tick(QTR);
      sda_m = 1'b1; tick(2*QTR);
   endtask

   task automatic bit_out(input logic b);
      sda_m = b;  tick(QTR);
      scl = 1'b1; tick(2*QTR);
      scl = 1'b0; tick(QTR);
   endtask

   task automatic bit_in(output logic b);
      sda_m = 1'b1; tick(QTR);
      scl = 1'b1;   tick(QTR);
      b = sda_line; tick(QTR);
      scl = 1'b0;   tick(QTR);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      logic v;
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(v);
      acked = (v == 1'b0);
   endtask

   task automatic recv_byte(output logic [7:0] b);
      for (int i = 7; i >= 0; i--) bit_in(b[i]);
   endtask

   // data bytes taken LSB byte first from dat
   task automatic write_regs(input logic [6:0] dev, input logic [7:0] ptr,
                             input logic [31:0] dat, input int n,
                             input bit expect_ack, input string req);
      bit ak;
      logic [AW-1:0] p;
      i2c_start();
      send_byte({dev, 1'b0}, ak);
      check(ak == expect_ack, req, ak, expect_ack);
      send_byte(ptr, ak);
      check(ak == expect_ack, expect_ack ? "R3 pointer ack" : "R2 pointer nack", ak, expect_ack);
      p = ptr[AW-1:0];
      for (int i = 0; i < n; i++) begin
         if (expect_ack) begin
            expq.push_back({p, dat[8*i +: 8]});
            exp_mem[p] = dat[8*i +: 8];
            p = p + 1'b1;
         end
         send_byte(dat[8*i +: 8], ak);
         check(ak == expect_ack, expect_ack ? "R4 data ack" : "R2 data nack", ak, expect_ack);
      end
      if (expect_ack) ptr_model = p;
      i2c_stop();
   endtask

   task automatic read_regs(input logic [6:0] dev, input bit set_ptr,
                            input logic [7:0] ptr, input int n, input string req);
      bit ak;
      logic [7:0] b;
      logic [AW-1:0] p;
      i2c_start();
      if (set_ptr) begin
         send_byte({dev, 1'b0}, ak);
         check(ak, "R1 address ack", ak, 1);
         send_byte(ptr, ak);
         check(ak, "R3 pointer ack", ak, 1);
         ptr_model = ptr[AW-1:0];
         i2c_start();
      end
      send_byte({dev, 1'b1}, ak);
      check(ak, "R5 read address ack", ak, 1);
      p = ptr_model;
      for (int i = 0; i < n; i++) begin
         recv_byte(b);
         check(b == exp_mem[p], req, b, exp_mem[p]);
         p = p + 1'b1;
         bit_out(i == n - 1);
      end
      ptr_model = p;
      recv_byte(b);
      check(b == 8'hFF, "R6 released after nack", b, 8'hFF);
      i2c_stop();
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      bit ak;
      logic [6:0] dev_ok;
      for (int i = 0; i < NREG; i++) begin
         regs[i]    = 8'(8'h40 + i * 3);
         exp_mem[i] = 8'(8'h40 + i * 3);
      end
      dev_ok = 7'b0010010;
      tick(4);
      check(sda_oe == 1'b0, "R10 reset sda_oe", sda_oe, 0);
      check(reg_we == 1'b0, "R10 reset reg_we", reg_we, 0);
      rst_n = 1'b1;
      tick(10);

      // R1 R3 R4: basic write burst
      write_regs(dev_ok, 8'h03, 32'h0000_3CA5, 2, 1'b1, "R1 address ack");
      // R5 R8: pointer write then repeated start read
      read_regs(dev_ok, 1'b1, 8'h03, 3, "R5 read data");
      // R5: read continues from pointer left by previous read
      read_regs(dev_ok, 1'b0, 8'h00, 2, "R5 read continue");

      // R2: wrong pin bits, then wrong prefix
      write_regs(7'b0010001, 8'h02, 32'h0000_0099, 1, 1'b0, "R2 pin mismatch");
      write_regs(7'b1010010, 8'h02, 32'h0000_0099, 1, 1'b0, "R2 prefix mismatch");

      // R7: write wrap 15 -> 0 -> 1, read wrap 14..1
      write_regs(dev_ok, 8'h0F, 32'h0033_2211, 3, 1'b1, "R7 address ack");
      read_regs(dev_ok, 1'b1, 8'h0E, 4, "R7 read wrap");

      // R8: start in the middle of a data byte
      i2c_start();
      send_byte({dev_ok, 1'b0}, ak);
      send_byte(8'h07, ak);
      bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
      i2c_start();
      send_byte({dev_ok, 1'b0}, ak);
      check(ak, "R8 ack after restart", ak, 1);
      send_byte(8'h08, ak);
      expq.push_back({4'h8, 8'h5A});
      exp_mem[8] = 8'h5A;
      send_byte(8'h5A, ak);
      i2c_stop();
      // R8: stop in the middle of a data byte
      i2c_start();
      send_byte({dev_ok, 1'b0}, ak);
      send_byte(8'h09, ak);
      bit_out(1'b0); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
      i2c_stop();
      read_regs(dev_ok, 1'b1, 8'h07, 3, "R8 no partial write");

      // R1 R2: new pin setting selects new address
      cfg_a1 = 1'b0; cfg_a0 = 1'b1;
      tick(4);
      write_regs(dev_ok, 8'h02, 32'h0000_0066, 1, 1'b0, "R2 old address after pin change");
      write_regs(7'b0010001, 8'h02, 32'h0000_0077, 1, 1'b1, "R1 new pin address");
      read_regs(7'b0010001, 1'b1, 8'h02, 1, "R1 read at new address");

      tick(20);
      check(expq.size() == 0, "R4 all writes seen", expq.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule